// File: doc/BRIEF.md
# Memory Checksum Accumulator

This block walks a program memory of 12-bit words and folds its contents into a 16-bit checksum. A single start pulse captures the configuration word and the four identifier words. The block then reads memory one word at a time through a request/valid port, beginning at address zero and counting upward. When the last word has been read, it adds a tail term and publishes the 16-bit result together with a one-cycle done pulse.

Bit 3 of the configuration word selects the code-protect mode. If that bit is 1, protection is off: every word in the array is summed. If that bit is 0, protection is on: only the low 64 words are summed, and a 16-bit value built from the low nibbles of the identifier words is added to the tail. In both modes the tail also holds the low four bits of the configuration word and the constant 0x0FF0. The sum is kept modulo 2^16.

The read port has exactly one request outstanding at a time. Memory may answer after any number of cycles, so the block can sit in front of a slow or arbitrated memory.

Top module: `mem_checksum_engine`

## Requirements
- R1: While reset is applied, and on the cycle after it, busy, done and rd_req are 0 and result is 0x0000.
- R2: A start pulse while idle begins a run. rd_req goes high for exactly one cycle per word. Addresses run 0, 1, 2, … in order. The next request is issued only after rd_valid has returned the previous word, and rd_addr holds steady while a word is awaited.
- R3: When cfg_word bit 3 is 1 (protection off), the words at addresses 0x000 through 0x7FF inclusive are summed.
- R4: When cfg_word bit 3 is 0 (protection on), only the words at addresses 0x000 through 0x03F are summed. No request is issued above 0x03F.
- R5: The running sum and the result keep only their low 16 bits. Carries beyond bit 15 are dropped.
- R6: In both modes the result also includes (cfg_word & 0x00F) + 0x0FF0.
- R7: With protection on, the result also includes the packed ID term. ID word k occupies id_words[12k+11:12k]. Its bits [3:0] land in term bits [15-4k:12-4k], so ID0 is the most significant nibble; for example, ID words 0xAB1, 0xCD2, 0xEF3, 0x564 give 0x1234. The upper eight bits of each ID word are not used. With protection off, the ID words have no effect.
- R8: Any number of cycles may pass between a request and its rd_valid. rd_valid while no word is awaited (for example while idle) is ignored.
- R9: A start pulse during a run is ignored, and so are changes to cfg_word or id_words during a run. The run completes with the values captured at its own start.
- R10: done is a single-cycle pulse, raised together with the new result while busy is low. result holds its value from one done pulse to the next.
- R11: An erased array (every word 0xFFF), checked with cfg_word 0xFFF, yields 0x07FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a checksum run (taken only while idle) |
| cfg_word | input | 12 | Configuration word; bit 3 is 0 for protected |
| id_words | input | 48 | Four identifier words, ID0 in bits [11:0] |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | 11 | Word address of the pending read |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 12 | Read data word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Checksum of the latest completed run |

## Verification
The bench builds the block with its default parameters: an 11-bit address, 12-bit words and a 16-bit sum. With these values a full unprotected run reads all 2048 words. That makes the erased-array value 0x07FF and the 16-bit wrap reachable, and the 64-word protected window is a real subset of the array. Memory latency is switched between a fixed single cycle and an address-dependent one to four cycles. Stray strobes while idle, a second start during a run and ID words changed mid-run are all applied while outputs are compared against a behavioural model on every clock.

// File: rtl/cks_pkg.sv
// Shared types for the memory checksum engine.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package cks_pkg;

    // Sequencer phases: idle, issue a read, await its data, fold in the tail.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_CLOSE = 2'd3
    } cks_state_e;

endpackage

// File: rtl/cks_ctrl.sv
// Run sequencer: accepts start while idle, issues one read per word and
// waits for its strobe, then closes the run with a tail step.
// Assumes: at_last reflects the address of the word currently awaited.
module cks_ctrl
    import cks_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_valid,
    input  logic at_last,
    output logic launch,
    output logic rd_req,
    output logic accept,
    output logic step,
    output logic close,
    output logic busy
);

    cks_state_e st_q;

    // Phase register: advance through issue/wait per word, then close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:  if (start) st_q <= ST_ISSUE;
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT:  if (rd_valid) st_q <= at_last ? ST_CLOSE : ST_ISSUE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes decoded from the current phase.
    always_comb begin
        launch = (st_q == ST_IDLE) && start;
        rd_req = (st_q == ST_ISSUE);
        accept = (st_q == ST_WAIT) && rd_valid;
        step   = accept && !at_last;
        close  = (st_q == ST_CLOSE);
        busy   = (st_q != ST_IDLE);
    end

endmodule

// File: rtl/cks_addr_gen.sv
// Word address counter: clears on launch, picks the last address from the
// protect mode, and advances one word per accepted read.
// Assumes: PROT_LAST fits in ADDR_W bits.
module cks_addr_gen #(
    parameter int ADDR_W    = 11,
    parameter int PROT_LAST = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              protect_in,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] FULL_LIM = '1;
    localparam logic [ADDR_W-1:0] PROT_LIM = ADDR_W'(PROT_LAST);

    logic [ADDR_W-1:0] last_q;

    // Address and limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            last_q <= FULL_LIM;
        end else if (launch) begin
            addr   <= '0;
            last_q <= protect_in ? PROT_LIM : FULL_LIM;
        end else if (step) begin
            addr   <= addr + 1'b1;
        end
    end

    // Final-word flag for the sequencer.
    always_comb at_last = (addr == last_q);

endmodule

// File: rtl/cks_terms.sv
// Tail-term builder: captures the configuration and ID words at launch and
// forms (cfg & CFG_MASK) + FIXED_ADD, plus the packed ID nibbles when protected.
// Assumes: SUM_W >= WORD_W; ID0 sits in the low word of id_words.
module cks_terms #(
    parameter int              WORD_W    = 12,
    parameter int              SUM_W     = 16,
    parameter int              ID_COUNT  = 4,
    parameter int              NIB_W     = 4,
    parameter int              CP_BIT    = 3,
    parameter logic [15:0]     CFG_MASK  = 16'h000F,
    parameter logic [15:0]     FIXED_ADD = 16'h0FF0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch,
    input  logic [WORD_W-1:0]          cfg_word,
    input  logic [ID_COUNT*WORD_W-1:0] id_words,
    output logic                       protect_now,
    output logic [SUM_W-1:0]           tail_term
);

    localparam int PACK_W = ID_COUNT * NIB_W;

    logic [WORD_W-1:0]          cfg_q;
    logic [ID_COUNT*WORD_W-1:0] ids_q;
    logic                       prot_q;
    logic [PACK_W-1:0]          pack_raw;
    logic [SUM_W-1:0]           pack_term;
    logic [ID_COUNT*WORD_W-1:0] ids_hi_unused;

    // Protect mode is active when the selected config bit is clear.
    always_comb protect_now = ~cfg_word[CP_BIT];

    // Capture of the run's configuration at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            ids_q  <= '0;
            prot_q <= 1'b0;
        end else if (launch) begin
            cfg_q  <= cfg_word;
            ids_q  <= id_words;
            prot_q <= protect_now;
        end
    end

    // Nibble packing: ID word k goes to nibble (ID_COUNT-1-k).
    for (genvar k = 0; k < ID_COUNT; k++) begin : g_pack
        assign pack_raw[(ID_COUNT-1-k)*NIB_W +: NIB_W] = ids_q[k*WORD_W +: NIB_W];
    end

    assign ids_hi_unused = ids_q;
    assign pack_term     = SUM_W'(pack_raw);

    // Tail sum of masked config, constant and optional ID term.
    always_comb begin
        tail_term = (SUM_W'(cfg_q) & SUM_W'(CFG_MASK)) + SUM_W'(FIXED_ADD);
        if (prot_q) tail_term = tail_term + pack_term;
    end

endmodule

// File: rtl/cks_accum.sv
// Modulo-2^SUM_W accumulator: clears on launch, adds each accepted word,
// and on close publishes accumulator plus tail with a one-cycle done.
// Assumes: launch, accept and close are mutually exclusive.
module cks_accum #(
    parameter int WORD_W = 12,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              accept,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              close,
    input  logic [SUM_W-1:0]  tail_term,
    output logic [SUM_W-1:0]  result,
    output logic              done
);

    logic [SUM_W-1:0] acc_q;

    // Running sum, truncated to SUM_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) acc_q <= '0;
        else if (accept)      acc_q <= acc_q + SUM_W'(rd_data);
    end

    // Published result and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= close;
            if (close) result <= acc_q + tail_term;
        end
    end

endmodule

// File: rtl/mem_checksum_engine.sv
// Top of the memory checksum engine: sequencer, address counter, tail-term
// builder and accumulator joined together.
// Assumes: memory answers every rd_req with exactly one rd_valid.
module mem_checksum_engine #(
    parameter int          WORD_W    = 12,
    parameter int          ADDR_W    = 11,
    parameter int          SUM_W     = 16,
    parameter int          PROT_LAST = 63,
    parameter int          ID_COUNT  = 4,
    parameter int          NIB_W     = 4,
    parameter int          CP_BIT    = 3,
    parameter logic [15:0] CFG_MASK  = 16'h000F,
    parameter logic [15:0] FIXED_ADD = 16'h0FF0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [WORD_W-1:0]          cfg_word,
    input  logic [ID_COUNT*WORD_W-1:0] id_words,
    output logic                       rd_req,
    output logic [ADDR_W-1:0]          rd_addr,
    input  logic                       rd_valid,
    input  logic [WORD_W-1:0]          rd_data,
    output logic                       busy,
    output logic                       done,
    output logic [SUM_W-1:0]           result
);

    logic launch, accept, step, close, at_last, protect_now;
    logic [SUM_W-1:0] tail_term;

    cks_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_valid (rd_valid),
        .at_last  (at_last),
        .launch   (launch),
        .rd_req   (rd_req),
        .accept   (accept),
        .step     (step),
        .close    (close),
        .busy     (busy)
    );

    cks_addr_gen #(.ADDR_W(ADDR_W), .PROT_LAST(PROT_LAST)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .protect_in (protect_now),
        .step       (step),
        .addr       (rd_addr),
        .at_last    (at_last)
    );

    cks_terms #(
        .WORD_W(WORD_W), .SUM_W(SUM_W), .ID_COUNT(ID_COUNT), .NIB_W(NIB_W),
        .CP_BIT(CP_BIT), .CFG_MASK(CFG_MASK), .FIXED_ADD(FIXED_ADD)
    ) u_terms (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .cfg_word    (cfg_word),
        .id_words    (id_words),
        .protect_now (protect_now),
        .tail_term   (tail_term)
    );

    cks_accum #(.WORD_W(WORD_W), .SUM_W(SUM_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .accept    (accept),
        .rd_data   (rd_data),
        .close     (close),
        .tail_term (tail_term),
        .result    (result),
        .done      (done)
    );

endmodule

// File: rtl/cks_checker.sv
// Port-level protocol checks for the memory checksum engine, bound to the top.
module cks_checker #(
    parameter int ADDR_W = 11,
    parameter int SUM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [SUM_W-1:0]  result
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !rd_req && result == '0));

    // R2
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_valid) |=> $stable(rd_addr));

    // R9
    req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind mem_checksum_engine cks_checker #(.ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .result   (result)
);

// File: tb/mem_checksum_engine_tb.sv
module mem_checksum_engine_tb;

    localparam int WORD_W = 12;
    localparam int ADDR_W = 11;
    localparam int SUM_W  = 16;
    localparam int IDN    = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [WORD_W-1:0]       cfg_word = '0;
    logic [IDN*WORD_W-1:0]   id_words = '0;
    logic                    rd_req, busy, done;
    logic [ADDR_W-1:0]       rd_addr;
    logic [SUM_W-1:0]        result;
    logic                    resp_v = 1'b0, stray_v = 1'b0;
    logic [WORD_W-1:0]       resp_d = '0, stray_d = '0;
    logic                    rd_valid;
    logic [WORD_W-1:0]       rd_data;

    assign rd_valid = resp_v | stray_v;
    assign rd_data  = resp_v ? resp_d : stray_d;

    mem_checksum_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
        .id_words(id_words), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
        .result(result)
    );

    integer n_checks = 0, n_fail = 0, cyc = 0;
    integer mem_mode = 0, lat_mode = 0;
    bit     cmp_en = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input integer act, input integer exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic integer mem_word(input integer a);
        case (mem_mode)
            0:       return 'hFFF;
            1:       return (a * 41 + 19) & 'hFFF;
            default: return (a ^ 'h5A5) & 'hFFF;
        endcase
    endfunction

    function automatic integer pack_ids(input logic [IDN*WORD_W-1:0] ids);
        return (integer'(ids[3:0]) << 12) | (integer'(ids[15:12]) << 8) |
               (integer'(ids[27:24]) << 4) | integer'(ids[39:36]);
    endfunction

    function automatic integer exp_sum(input logic [WORD_W-1:0] cfg,
                                       input logic [IDN*WORD_W-1:0] ids);
        integer s = 0;
        integer top = cfg[3] ? 2047 : 63;
        for (integer a = 0; a <= top; a++) s += mem_word(a);
        s += (cfg & 'hF) + 'hFF0;
        if (!cfg[3]) s += pack_ids(ids);
        return s & 'hFFFF;
    endfunction

    // Memory responder with selectable latency.
    integer pend = -1, paddr = 0;
    always @(negedge clk) begin
        resp_v <= 1'b0;
        if (!rst_n) pend = -1;
        if (pend > 0) pend--;
        if (pend == 0) begin
            resp_v <= 1'b1;
            resp_d <= WORD_W'(mem_word(paddr));
            pend = -1;
        end
        if (rd_req && rst_n) begin
            paddr = integer'(rd_addr);
            pend  = (lat_mode == 0) ? 1 : (paddr % 4) + 1;
        end
    end

    // Behavioural reference, advanced on every rising edge.
    integer m_state = 0, m_addr = 0, m_last = 0, m_acc = 0, m_result = 0;
    bit     m_done = 0, m_prot = 0;
    logic [WORD_W-1:0]     m_cfg;
    logic [IDN*WORD_W-1:0] m_ids;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_done = 0; m_result = 0; m_addr = 0;
        end else begin
            m_done = 0;
            case (m_state)
                0: if (start) begin
                    m_cfg = cfg_word; m_ids = id_words; m_prot = !cfg_word[3];
                    m_last = m_prot ? 63 : 2047; m_acc = 0; m_addr = 0; m_state = 1;
                end
                1: m_state = 2;
                2: if (rd_valid) begin
                    m_acc = (m_acc + integer'(rd_data)) & 'hFFFF;
                    if (m_addr == m_last) m_state = 3;
                    else begin m_addr++; m_state = 1; end
                end
                default: begin
                    m_result = (m_acc + (m_cfg & 'hF) + 'hFF0 +
                                (m_prot ? pack_ids(m_ids) : 0)) & 'hFFFF;
                    m_done = 1; m_state = 0;
                end
            endcase
        end
    end

    // Clock-by-clock comparison against the reference.
    always @(negedge clk) begin
        if (cmp_en) begin
            check(busy == (m_state != 0), "R2", "busy", busy, m_state != 0);
            check(done == m_done, "R10", "done", done, m_done);
            check(integer'(result) == m_result, "R10", "result", result, m_result);
            check(rd_req == (m_state == 1), "R2", "rd_req", rd_req, m_state == 1);
            if (rd_req) check(integer'(rd_addr) == m_addr, "R2", "rd_addr", rd_addr, m_addr);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 190000) begin
            check(1'b0, "R2", "watchdog expired", cyc, 190000);
            finish_run();
        end
    end

    task automatic pulse_start(input logic [WORD_W-1:0] cfg, input logic [IDN*WORD_W-1:0] ids);
        @(negedge clk);
        cfg_word = cfg; id_words = ids; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (integer i = 0; i < 20000 && !done; i++) @(negedge clk);
    endtask

    task automatic run_job(input logic [WORD_W-1:0] cfg, input logic [IDN*WORD_W-1:0] ids,
                           input string req);
        integer e;
        e = exp_sum(cfg, ids);
        pulse_start(cfg, ids);
        wait_done();
        check(done == 1'b1, req, "done seen", done, 1);
        check(integer'(result) == e, req, "checksum", result, e);
    endtask

    logic [IDN*WORD_W-1:0] ids_a = {12'h564, 12'hEF3, 12'hCD2, 12'hAB1};
    logic [SUM_W-1:0] keep;
    integer e_a;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !rd_req, "R1", "control outputs in reset",
              {busy, done, rd_req}, 0);
        check(result == '0, "R1", "result in reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && result == '0, "R1", "idle after reset", result, 0);
        cmp_en = 1'b1;

        // R11 / R3 / R5: erased array, all words read, sum wraps
        mem_mode = 0; lat_mode = 0;
        run_job(12'hFFF, '0, "R3");
        check(result == 16'h07FF, "R11", "blank checksum", result, 16'h07FF);

        // R8: stray strobes while idle have no effect
        keep = result;
        @(negedge clk); stray_v = 1'b1; stray_d = 12'h123;
        @(negedge clk); stray_v = 1'b0;
        repeat (3) @(negedge clk);
        check(result == keep && !busy, "R8", "stray valid ignored", result, keep);

        // R4 / R6 / R7: protected window with packed IDs
        mem_mode = 1; lat_mode = 1;
        run_job(12'hFF7, ids_a, "R4");
        check(result == 16'h69CB, "R7", "protected with IDs", result, 16'h69CB);

        // R10: result holds between runs
        keep = result;
        repeat (40) @(negedge clk);
        check(result == keep && !done, "R10", "result held", result, keep);

        // R7 / R5 / R8: unprotected, variable latency, IDs have no effect
        run_job(12'hFFA, ids_a, "R5");
        keep = result;
        lat_mode = 0;
        run_job(12'hFFA, '0, "R7");
        check(result == keep, "R7", "IDs ignored when unprotected", result, keep);

        // R6: mask keeps only low config nibble
        mem_mode = 2;
        run_job(12'h00C, '0, "R6");
        run_job(12'hFF8, '0, "R6");

        // R9: start and input changes during a run are ignored
        mem_mode = 1;
        e_a = exp_sum(12'hFF3, ids_a);
        pulse_start(12'hFF3, ids_a);
        repeat (30) @(negedge clk);
        cfg_word = 12'hFFF; id_words = '0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        check(integer'(result) == e_a, "R9", "restart ignored", result, e_a);
        repeat (5) @(negedge clk);
        check(!busy, "R9", "no second run", busy, 0);

        finish_run();
    end

endmodule